// File: doc/BRIEF.md
# Programmable Clock Ratio Generator

This block derives three clock-enable streams from one input clock: one for the processor core, one for the system bus and one for the peripheral domain. Each stream is a pulse that lasts one cycle and repeats every N input clocks. N is that domain's ratio. A ratio of 1 holds the enable high. Other logic running on the input clock qualifies its registers with these enables. No clock is gated.

Software sets the ratios by writing one frequency control register through a plain write port. Three 3-bit fields in that register choose a ratio for each domain. The core and bus fields share one ratio table and the peripheral field has its own. Both tables include ratios that are not powers of two. Codes that are officially reserved decode to the largest ratio, 8.

A new ratio waits until the current period of its divider ends, so no period is ever cut short. The block reports the ratio each divider is currently using. It also raises a strobe for one cycle after any write that changes the peripheral ratio. Peripherals that derive rates from that domain, such as baud generators, use the strobe to recompute.

Top module: `clk_ratio_gen`

## Requirements
- R1: The register fields are decoded as follows: bits 8:6 select the core ratio, bits 5:3 select the bus ratio and bits 2:0 select the peripheral ratio.
- R2: The core and bus fields map codes 0 through 7 to ratios 1, 2, 3, 4, 5, 8, 8 and 8. Reserved codes 6 and 7 therefore give 8.
- R3: The peripheral field maps codes 0 through 7 to ratios 2, 3, 4, 6, 8, 8, 8 and 8. Reserved codes 5 to 7 therefore give 8.
- R4: After reset, the register reads 0, the core and bus ratios are 1 with their enables held high, and the peripheral ratio is 2.
- R5: Each enable is high for exactly one cycle in every N cycles, where N is the domain's active ratio. A ratio of 1 keeps the enable high every cycle.
- R6: A newly written ratio is loaded only when the current period of its divider ends. The period that is running when the write lands keeps its old length.
- R7: The ratio outputs report the ratio each divider is currently counting, as an unsigned binary value. They change only in the cycle after a terminal count.
- R8: `per_ratio_chg` is high for exactly one cycle, the cycle after a write whose peripheral field decodes to a different ratio from the pending one. A write that leaves the decoded peripheral ratio unchanged does not raise it.
- R9: `rd_data` returns the full value most recently written, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that every enable is derived from |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the frequency control register |
| wr_data | input | REG_W | Value to write |
| rd_data | output | REG_W | Current register contents |
| cpu_en | output | 1 | Core clock enable |
| bus_en | output | 1 | Bus clock enable |
| per_en | output | 1 | Peripheral clock enable |
| cpu_ratio | output | RATIO_W | Active core ratio |
| bus_ratio | output | RATIO_W | Active bus ratio |
| per_ratio | output | RATIO_W | Active peripheral ratio |
| per_ratio_chg | output | 1 | One-cycle pulse after a write that changes the peripheral ratio |

## Verification
The hardest case to reach is a write that lands partway through a long divider period, because only then can a shortened period show up. The stimulus first sets the peripheral ratio to 8. It then waits until it sees a peripheral pulse and issues the write for ratio 2 one cycle later. It measures the gap that contains the write and expects 8, then measures the next gap and expects 2. A second hard case is a write that changes the code but not the decoded ratio, moving from one reserved code to another. This case checks that the change strobe stays low.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
    localparam int CODE_W  = 3;
    localparam int RATIO_W = 4;

    typedef enum logic { TBL_CORE = 1'b0, TBL_PERIPH = 1'b1 } tbl_kind_e;

    // Core/bus table; reserved codes saturate at 8
    function automatic logic [RATIO_W-1:0] core_ratio(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    core_ratio = RATIO_W'(1);
            3'd1:    core_ratio = RATIO_W'(2);
            3'd2:    core_ratio = RATIO_W'(3);
            3'd3:    core_ratio = RATIO_W'(4);
            3'd4:    core_ratio = RATIO_W'(5);
            default: core_ratio = RATIO_W'(8);
        endcase
    endfunction

    // Peripheral table; reserved codes saturate at 8
    function automatic logic [RATIO_W-1:0] periph_ratio(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    periph_ratio = RATIO_W'(2);
            3'd1:    periph_ratio = RATIO_W'(3);
            3'd2:    periph_ratio = RATIO_W'(4);
            3'd3:    periph_ratio = RATIO_W'(6);
            default: periph_ratio = RATIO_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/ratio_lut.sv
module ratio_lut
    import clk_ratio_pkg::*;
#(
    parameter tbl_kind_e KIND = TBL_CORE
) (
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio
);
    generate
        if (KIND == TBL_PERIPH) begin : g_periph
            assign ratio = periph_ratio(code);
        end else begin : g_core
            assign ratio = core_ratio(code);
        end
    endgenerate
endmodule

// File: rtl/pulse_divider.sv
module pulse_divider #(
    parameter int RATIO_W = 4,
    parameter logic [RATIO_W-1:0] RST_RATIO = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] next_ratio,
    output logic               en,
    output logic [RATIO_W-1:0] ratio
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] act;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    term;

    // Terminal count: last cycle of the running period
    assign term  = (st_q.cnt == st_q.act - RATIO_W'(1));
    assign en    = term;
    assign ratio = st_q.act;

    always_comb begin
        st_d = st_q;
        if (term) begin
            st_d.cnt = '0;
            st_d.act = next_ratio;   // new ratio only at period end
        end else begin
            st_d.cnt = st_q.cnt + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= RST_RATIO;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import clk_ratio_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic               cpu_en,
    output logic               bus_en,
    output logic               per_en,
    output logic [RATIO_W-1:0] cpu_ratio,
    output logic [RATIO_W-1:0] bus_ratio,
    output logic [RATIO_W-1:0] per_ratio,
    output logic               per_ratio_chg
);
    // Domain index 0 = peripheral (bits 2:0), 1 = bus (5:3), 2 = core (8:6)
    localparam int NDOM  = 3;
    localparam int FLD_W = NDOM * CODE_W;

    typedef struct packed {
        logic [REG_W-1:0] fcr;
        logic             chg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NDOM-1:0]              dom_en;
    logic [NDOM-1:0][RATIO_W-1:0] dom_pend;
    logic [NDOM-1:0][RATIO_W-1:0] dom_act;
    logic [RATIO_W-1:0]           wr_per_ratio;

    generate
        for (genvar g = 0; g < NDOM; g++) begin : g_dom
            localparam tbl_kind_e KIND = tbl_kind_e'(g == 0);
            localparam logic [RATIO_W-1:0] RST_R =
                (g == 0) ? periph_ratio('0) : core_ratio('0);

            ratio_lut #(.KIND(KIND)) u_lut (
                .code  (st_q.fcr[g*CODE_W +: CODE_W]),
                .ratio (dom_pend[g])
            );

            pulse_divider #(.RATIO_W(RATIO_W), .RST_RATIO(RST_R)) u_div (
                .clk        (clk),
                .rst_n      (rst_n),
                .next_ratio (dom_pend[g]),
                .en         (dom_en[g]),
                .ratio      (dom_act[g])
            );
        end
    endgenerate

    // Decode of the incoming peripheral field for change detection
    ratio_lut #(.KIND(TBL_PERIPH)) u_wr_lut (
        .code  (wr_data[CODE_W-1:0]),
        .ratio (wr_per_ratio)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (wr_en) begin
            st_d.fcr = wr_data;
            st_d.chg = (wr_per_ratio != dom_pend[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data       = st_q.fcr;
    assign per_ratio_chg = st_q.chg;
    assign per_en        = dom_en[0];
    assign bus_en        = dom_en[1];
    assign cpu_en        = dom_en[2];
    assign per_ratio     = dom_act[0];
    assign bus_ratio     = dom_act[1];
    assign cpu_ratio     = dom_act[2];

    if (REG_W < FLD_W) begin : g_bad_width
        initial $error("REG_W too small for the ratio fields");
    end
endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk
    import clk_ratio_pkg::*;
#(
    parameter int REG_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic [REG_W-1:0]   rd_data,
    input logic               cpu_en,
    input logic               bus_en,
    input logic               per_en,
    input logic [RATIO_W-1:0] cpu_ratio,
    input logic [RATIO_W-1:0] bus_ratio,
    input logic [RATIO_W-1:0] per_ratio,
    input logic               per_ratio_chg
);
    p_one_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ratio == RATIO_W'(1)) |-> cpu_en);
    p_per_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |=> !per_en);
    p_cpu_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |=> (cpu_ratio == RATIO_W'(1) || !cpu_en));
    p_hold_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(bus_ratio));
    p_per_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_ratio >= RATIO_W'(2) && per_ratio <= RATIO_W'(8));
    p_core_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ratio != RATIO_W'(0) && cpu_ratio != RATIO_W'(6) && cpu_ratio != RATIO_W'(7) && cpu_ratio <= RATIO_W'(8));
    p_chg_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_ratio_chg |-> $past(wr_en));
    p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data == $past(wr_data));
endmodule

bind clk_ratio_gen clk_ratio_gen_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_clk_ratio_gen.sv
module sim_clk_ratio_gen;
    localparam int REG_W   = 16;
    localparam int RATIO_W = 4;
    localparam time CLK_PER = 10ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [REG_W-1:0]   wr_data = '0;
    logic [REG_W-1:0]   rd_data;
    logic               cpu_en, bus_en, per_en, per_ratio_chg;
    logic [RATIO_W-1:0] cpu_ratio, bus_ratio, per_ratio;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    clk_ratio_gen #(.REG_W(REG_W)) u0 (.*);

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic write_reg(input logic [REG_W-1:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic dom_en(input int d);
        return (d == 0) ? per_en : (d == 1) ? bus_en : cpu_en;
    endfunction

    function automatic int dom_ratio(input int d);
        return (d == 0) ? int'(per_ratio) : (d == 1) ? int'(bus_ratio) : int'(cpu_ratio);
    endfunction

    task automatic wait_pulse(input int d);
        for (int i = 0; i < 64 && !dom_en(d); i++) tick();
    endtask

    task automatic gap(input int d, output int n);
        n = 0;
        wait_pulse(d);
        do begin tick(); n++; end while (!dom_en(d) && n < 64);
    endtask

    function automatic int exp_core(input int c);
        int t [8] = '{1, 2, 3, 4, 5, 8, 8, 8};
        return t[c];
    endfunction

    function automatic int exp_per(input int c);
        int t [8] = '{2, 3, 4, 6, 8, 8, 8, 8};
        return t[c];
    endfunction

    task automatic t_reset();
        check("R4 reg", int'(rd_data), 0);
        check("R4 cpu ratio", int'(cpu_ratio), 1);
        check("R4 bus ratio", int'(bus_ratio), 1);
        check("R4 per ratio", int'(per_ratio), 2);
        for (int i = 0; i < 4; i++) begin
            check("R4 R5 cpu_en high", int'(cpu_en), 1);
            check("R4 R5 bus_en high", int'(bus_en), 1);
            tick();
        end
    endtask

    // R1 R2 R3 R5 R7: every code in every field
    task automatic t_tables();
        int n;
        for (int d = 0; d < 3; d++) begin
            for (int c = 0; c < 8; c++) begin
                write_reg(REG_W'(c << (3*d)));
                check("R9 readback", int'(rd_data), c << (3*d));
                repeat (20) tick();
                gap(d, n);
                check(d == 0 ? "R3 R5 per gap" : "R2 R1 R5 core/bus gap", n,
                      d == 0 ? exp_per(c) : exp_core(c));
                check("R7 ratio out", dom_ratio(d), d == 0 ? exp_per(c) : exp_core(c));
            end
        end
    endtask

    // R6: a write mid-period does not shorten it
    task automatic t_no_shorten();
        int n;
        write_reg(REG_W'(4));
        repeat (20) tick();
        wait_pulse(0);
        wr_en = 1'b1; wr_data = REG_W'(0);
        tick(); n = 1;
        wr_en = 1'b0;
        check("R6 ratio held mid-period", int'(per_ratio), 8);
        while (!per_en && n < 64) begin tick(); n++; end
        check("R6 gap with write", n, 8);
        gap(0, n);
        check("R6 next gap new ratio", n, 2);
    endtask

    // R8: change strobe
    task automatic t_strobe();
        write_reg(REG_W'(1));
        repeat (3) tick();
        write_reg(REG_W'(3));
        check("R8 strobe on change", int'(per_ratio_chg), 1);
        tick();
        check("R8 strobe one cycle", int'(per_ratio_chg), 0);
        write_reg(REG_W'(4));
        check("R8 strobe 6->8", int'(per_ratio_chg), 1);
        tick();
        write_reg(REG_W'(7));
        check("R8 no strobe reserved same ratio", int'(per_ratio_chg), 0);
        write_reg(REG_W'(7 | (3 << 6)));
        check("R8 no strobe core-only change", int'(per_ratio_chg), 0);
        check("R9 readback full", int'(rd_data), 7 | (3 << 6));
        write_reg(REG_W'(16'hA5C0));
        check("R9 upper bits kept", int'(rd_data), 16'hA5C0);
        check("R8 strobe 8->2", int'(per_ratio_chg), 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_tables();
        t_no_shorten();
        t_strobe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule